// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Detector

This block watches a vector of general-purpose pins, split into equal groups, and raises one interrupt request per group when any selected pin in that group changes level. Every pin has its own select bit; a pin whose select bit is clear never raises its group's flag. Rising and falling transitions count equally. Pins are watched whether the surrounding logic drives them as inputs or as outputs, so software can raise an interrupt by toggling one of its own outputs.

Each pin passes through a fixed sampling pipeline: a capture stage, a synchronizing stage, and a compare stage that holds the previous synchronized value. The compare result is masked and combined across the group, and it sets a sticky group flag. The flag stays set until software clears it with a write-one pulse or the interrupt controller acknowledges it. A sample enable input freezes the sampling pipeline and blocks new flag sets. While it is low, clearing still works.

Top module: `pin_chg_irq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every bit of `grp_flag` and `grp_irq` is 0. Reset must be held for at least three clock cycles with the pins steady. The pipeline follows the pins during reset, so no change is seen when reset is released.
- R2: A level change on a pin whose select bit in `pin_mask` is 1 sets its group flag. The pin may rise or fall. If the pin changes between two clock edges, the flag first reads 1 after the third rising edge that follows. It reads 0 after the first and second of those edges.
- R3: A change on a pin whose select bit is 0 never sets a flag.
- R4: Once set, a group flag stays 1 until that group's clear or acknowledge input is sampled high.
- R5: If bit g of `flag_clr` or of `flag_ack` is high at a rising edge and group g sees no new change there, flag g reads 0 after that edge.
- R6: If a new selected change reaches the compare stage of group g at the same edge as a clear or acknowledge for group g, flag g stays 1.
- R7: Group g is made of pin and mask bits [g*GRP_W +: GRP_W]. A change in one group touches no other group's flag.
- R8: `grp_irq` always equals `grp_flag`.
- R9: While `sample_en` is 0, no flag is set and the sampling pipeline holds its contents. A pin change made during that time sets the flag after the third rising edge with `sample_en` high.
- R10: A pulse that lasts one clock cycle on a selected pin sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_GRP*GRP_W | Raw pin levels |
| pin_mask | input | NUM_GRP*GRP_W | Per-pin select; 1 lets the pin contribute |
| sample_en | input | 1 | Sampling enable (clock gate) |
| flag_clr | input | NUM_GRP | Write-one-to-clear pulse per group |
| flag_ack | input | NUM_GRP | Interrupt acknowledge per group |
| grp_flag | output | NUM_GRP | Sticky change flag per group |
| grp_irq | output | NUM_GRP | Interrupt request per group |

## Verification
The assertions watch several relations on every cycle: the flag is sticky, a clear or acknowledge takes effect, a selected change always sets the flag, a quiet or deselected group never sets it, and nothing sets while sampling is gated. They tie the compare-stage output to the flag register, but they cannot see the full path from the pin to the flag. Only the bench scenarios can show the exact three-edge latency from a pin edge, that groups stay independent, that a one-cycle pulse is caught, and that a change made while gated shows up later. The bench reaches these through a behavioural sample-history model that is compared every clock.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int DEF_NUM_GRP = 3;
    localparam int DEF_GRP_W   = 8;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_ctl_t;

    function automatic logic flag_next(flag_ctl_t c, logic cur);
        return c.set | (cur & ~c.clr);
    endfunction

endpackage

// File: rtl/pcd_pin_pipe.sv
module pcd_pin_pipe #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] pin,
    output logic [W-1:0] chg
);
    logic [W-1:0] cap_q;
    logic [W-1:0] syn_q;
    logic [W-1:0] old_q;

    always_ff @(posedge clk) begin
        if (rst || en) begin
            cap_q <= pin;
            syn_q <= cap_q;
            old_q <= syn_q;
        end
    end

    assign chg = syn_q ^ old_q;
endmodule

// File: rtl/pcd_grp_flag.sv
module pcd_grp_flag
    import pcd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] chg,
    input  logic [W-1:0] mask,
    input  logic         clr,
    input  logic         ack,
    output logic         flag
);
    flag_ctl_t ctl;
    logic      hit;

    assign hit     = |(chg & mask);
    assign ctl.set = en & hit;
    assign ctl.clr = clr | ack;

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= flag_next(ctl, flag);
    end

    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (en && |(chg & mask)) |=> flag); // R2

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!flag && !(|(chg & mask))) |=> !flag); // R3

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr && !ack) |=> flag); // R4

    AST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flag && (clr || ack) && !(en && |(chg & mask))) |=> !flag); // R5

    AST_GATED_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (!flag && !en) |=> !flag); // R9
endmodule

// File: rtl/pin_chg_irq.sv
module pin_chg_irq
    import pcd_pkg::*;
#(
    parameter int NUM_GRP = DEF_NUM_GRP,
    parameter int GRP_W   = DEF_GRP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_GRP*GRP_W-1:0] pin_in,
    input  logic [NUM_GRP*GRP_W-1:0] pin_mask,
    input  logic                     sample_en,
    input  logic [NUM_GRP-1:0]       flag_clr,
    input  logic [NUM_GRP-1:0]       flag_ack,
    output logic [NUM_GRP-1:0]       grp_flag,
    output logic [NUM_GRP-1:0]       grp_irq
);
    localparam int NPIN = NUM_GRP * GRP_W;

    logic [NPIN-1:0] chg_all;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        pcd_pin_pipe #(.W(GRP_W)) u_pipe (
            .clk (clk),
            .rst (rst),
            .en  (sample_en),
            .pin (pin_in[g*GRP_W +: GRP_W]),
            .chg (chg_all[g*GRP_W +: GRP_W])
        );

        pcd_grp_flag #(.W(GRP_W)) u_flag (
            .clk  (clk),
            .rst  (rst),
            .en   (sample_en),
            .chg  (chg_all[g*GRP_W +: GRP_W]),
            .mask (pin_mask[g*GRP_W +: GRP_W]),
            .clr  (flag_clr[g]),
            .ack  (flag_ack[g]),
            .flag (grp_flag[g])
        );
    end

    assign grp_irq = grp_flag;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (grp_flag == '0)); // R1

    AST_IRQ_FOLLOWS: assert property (@(posedge clk)
        grp_irq == grp_flag); // R8
endmodule

// File: tb/tb_pin_chg_irq.sv
`timescale 1ns/1ps
module tb_pin_chg_irq;
    localparam int NG = 3;
    localparam int GW = 8;
    localparam int NP = NG * GW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_mask = '1;
    logic          sample_en = 1'b1;
    logic [NG-1:0] flag_clr = '0;
    logic [NG-1:0] flag_ack = '0;
    logic [NG-1:0] grp_flag;
    logic [NG-1:0] grp_irq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pin_chg_irq #(.NUM_GRP(NG), .GRP_W(GW)) dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_mask(pin_mask),
        .sample_en(sample_en), .flag_clr(flag_clr), .flag_ack(flag_ack),
        .grp_flag(grp_flag), .grp_irq(grp_irq)
    );

    // Behavioural model: history of pin samples taken at enabled edges
    logic [NP-1:0] hist[$];
    logic [NG-1:0] mflag = '0;

    always @(posedge clk) begin
        logic [NP-1:0] d;
        logic [NG-1:0] setv;
        setv = '0;
        if (rst) begin
            mflag = '0;
            hist.push_back(pin_in);
        end else if (sample_en) begin
            if (hist.size() >= 3) begin
                d = (hist[hist.size()-2] ^ hist[hist.size()-3]) & pin_mask;
                for (int g = 0; g < NG; g++) setv[g] = |d[g*GW +: GW];
            end
            mflag = setv | (mflag & ~(flag_clr | flag_ack));
            hist.push_back(pin_in);
        end else begin
            mflag = mflag & ~(flag_clr | flag_ack);
        end
        while (hist.size() > 3) void'(hist.pop_front());
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (grp_flag !== mflag) begin
                errors++;
                $display("FAIL R2 model compare: flag=%b expected=%b at %0t", grp_flag, mflag, $time);
            end
            checks++;
            if (grp_irq !== grp_flag) begin
                errors++;
                $display("FAIL R8 irq=%b expected=%b", grp_irq, grp_flag);
            end
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic expect_flags(logic [NG-1:0] exp, string tag);
        checks++;
        if (grp_flag !== exp) begin
            errors++;
            $display("FAIL %s: flag=%b expected=%b", tag, grp_flag, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step(5);
        expect_flags(3'b000, "R1 during reset");
        rst = 1'b0;
        step(1);
        expect_flags(3'b000, "R1 after reset");

        // R2 rising edge on pin 3, group 0: exact latency of three edges
        pin_in[3] = 1'b1;
        step(2);
        expect_flags(3'b000, "R2 not yet after two edges");
        step(1);
        expect_flags(3'b001, "R2 set after third edge");
        checks++;
        if (grp_irq !== 3'b001) begin
            errors++;
            $display("FAIL R8 irq=%b expected=001", grp_irq);
        end

        // R4 sticky
        step(6);
        expect_flags(3'b001, "R4 sticky");

        // R6 set wins: falling edge on pin 3, clear lands on the set edge
        pin_in[3] = 1'b0;
        step(2);
        flag_clr[0] = 1'b1;
        step(1);
        flag_clr[0] = 1'b0;
        expect_flags(3'b001, "R6 set beats clear");

        // R5 clear by write-one pulse
        flag_clr[0] = 1'b1;
        step(1);
        flag_clr[0] = 1'b0;
        expect_flags(3'b000, "R5 w1c clear");

        // R7 falling edge on pin 16 (group 2) only touches group 2
        pin_in[16] = 1'b1;
        step(3);
        flag_clr[2] = 1'b1;
        step(1);
        flag_clr[2] = 1'b0;
        step(1);
        pin_in[16] = 1'b0;
        step(3);
        expect_flags(3'b100, "R7 group 2 alone on fall");
        flag_ack[2] = 1'b1;
        step(1);
        flag_ack[2] = 1'b0;
        expect_flags(3'b000, "R5 ack clear");

        // R3 deselected pin 9 toggles, group 1 stays quiet
        pin_mask[9] = 1'b0;
        pin_in[9] = 1'b1;
        step(2);
        pin_in[9] = 1'b0;
        step(6);
        expect_flags(3'b000, "R3 masked pin ignored");
        pin_mask[9] = 1'b1;

        // R5 ack on group 1 after pin 12 rises
        pin_in[12] = 1'b1;
        step(3);
        expect_flags(3'b010, "R7 group 1 set");
        flag_ack[1] = 1'b1;
        step(1);
        flag_ack[1] = 1'b0;
        expect_flags(3'b000, "R5 ack clears group 1");

        // R9 gated: change during gate low shows up three enabled edges later
        sample_en = 1'b0;
        pin_in[5] = 1'b1;
        step(6);
        expect_flags(3'b000, "R9 no set while gated");
        sample_en = 1'b1;
        step(2);
        expect_flags(3'b000, "R9 still pending");
        step(1);
        expect_flags(3'b001, "R9 set after re-enable");
        flag_clr = '1;
        step(1);
        flag_clr = '0;
        expect_flags(3'b000, "R5 clear all");

        // R10 single-cycle pulse on pin 20
        step(2);
        pin_in[20] = 1'b1;
        step(1);
        pin_in[20] = 1'b0;
        step(2);
        expect_flags(3'b100, "R10 pulse caught");
        step(4);
        expect_flags(3'b100, "R10 flag held");

        step(2);
        finish_run();
    end
endmodule